// File: doc/BRIEF.md
# Bank Row-Buffer Command Sequencer

This block drives a single DRAM bank. It keeps track of whether the bank's row buffer currently holds a row, and which row that is. It turns each read or write request into the activate, column-access and precharge commands the bank needs. A static input selects the page policy. In open-page mode a row stays in the buffer after an access, so a later access to the same row needs only a column command. In close-page mode the row is precharged in the cycle after every column access, so the bank is always closed when idle.

The sequencer waits out four minimum spacings, each set by a parameter. These are activate-to-activate, activate-to-column, precharge-to-activate and write-to-read. It also refreshes the bank one row at a time. Each refresh tick requests a refresh of the next row from a wrapping counter. A pending refresh wins over new requests but never breaks into an access that has already activated its row. The requester holds its request until the done pulse. The done pulse appears in the same cycle as the request's column command. A status pair reports the open row, so a scheduler can recognise row hits.

Top module: `bankRowSequencer`

## Requirements
- R1: A request to a closed bank is served by an activate (kind 1) of the request row, followed after exactly T_RCD cycles, when nothing else delays it, by a read (kind 2) or write (kind 3) carrying the request column. `reqDone` is high only in the cycle of that column command.
- R2: Under open-page mode (`closePolicy`=0), a request to the row already open is served by a single column command, with no activate and no precharge.
- R3: A request to a different row while a row is open first precharges (kind 4) the open row. The activate of the new row comes no sooner than T_RP cycles after that precharge.
- R4: Under close-page mode (`closePolicy`=1), a precharge follows every column command in the next cycle. A later request to the same row therefore starts with an activate, never with a precharge.
- R5: Two activates or refreshes are never closer than T_RC cycles. When the precharge clears early, the second activate lands exactly T_RC cycles after the first.
- R6: A read is never issued sooner than T_WTR cycles after a write. A read that is waiting only on this rule is issued exactly T_WTR cycles after the write.
- R7: Each refresh command (kind 5) carries the refresh row counter on `cmdRow`. The counter starts at 0 after reset, advances by one per refresh, and wraps from 2**ROW_W-1 to 0.
- R8: A pending refresh is served before any request that has not yet activated its row, with the open row precharged first. An access whose activate has already been issued completes its column command before the refresh sequence begins.
- R9: `rowOpen` is 1 exactly while the buffer holds a row, and `openRow` then gives its index. After reset, no command is issued and `rowOpen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| closePolicy | input | 1 | Static page policy: 0 keeps rows open, 1 closes after each access |
| reqValid | input | 1 | Request present; held until `reqDone` |
| reqRow | input | ROW_W | Row of the request |
| reqCol | input | COL_W | Column of the request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| refreshTick | input | 1 | One-cycle pulse asking for one row refresh |
| reqDone | output | 1 | High in the cycle the request's column command is issued |
| cmdValid | output | 1 | A command is issued this cycle |
| cmdKind | output | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh |
| cmdRow | output | ROW_W | Row for activate, precharge, column or refresh commands |
| cmdCol | output | COL_W | Column for read and write commands, else 0 |
| rowOpen | output | 1 | Row buffer holds a row |
| openRow | output | ROW_W | Index of the open row |

## Verification
The bench targets the places where the command order or the spacing is easy to get wrong. One is a refresh tick that arrives while a row-hit request is waiting: a sequencer that checks for hits before refresh would answer the request and leave the refresh pending. Another is a tick that arrives between an activate and its column command: a sequencer that lets refresh preempt here would precharge the freshly opened row, and the logged order would show a precharge before the read. The bench also checks the gaps between commands at their exact edges: activate to activate where the precharge cleared early, write to read on a row hit, and activate to column. A timer that is off by one makes one of these gaps short or long by a cycle. Finally, sixteen back-to-back refreshes expose a row counter that fails to wrap or skips a row.

// File: rtl/bankSeqPkg.sv
package bankSeqPkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmdKind_e;

  // one strobe per bank command, at most one set per cycle
  typedef struct packed {
    logic doAct;
    logic doPre;
    logic doRd;
    logic doWr;
    logic doRef;
  } seqStrobes_t;

endpackage

// File: rtl/seqDelayTimer.sv
module seqDelayTimer #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic load,
  output logic ready
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  // after load in cycle t, ready again in cycle t+LIMIT
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (load)          cnt <= CW'(LIMIT - 1);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign ready = (cnt == '0);
endmodule

// File: rtl/bankSeqCtrl.sv
module bankSeqCtrl
  import bankSeqPkg::*;
#(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             closePolicy,
  input  logic             reqValid,
  input  logic [ROW_W-1:0] reqRow,
  input  logic             reqWrite,
  input  logic             rowOpen,
  input  logic [ROW_W-1:0] openRow,
  input  logic             refPending,
  input  logic             rcReady,
  input  logic             rcdReady,
  input  logic             rpReady,
  input  logic             wtrReady,
  output seqStrobes_t      st,
  output logic             reqDone
);
  logic inProg;   // the held request has activated its row
  logic rowHit;
  logic colOk;

  assign rowHit = rowOpen && (openRow == reqRow);
  assign colOk  = rcdReady && (reqWrite || wtrReady);

  always_comb begin
    st = '0;
    if (inProg) begin
      if (colOk) begin
        st.doRd = !reqWrite;
        st.doWr = reqWrite;
      end
    end else if (rowOpen && (closePolicy || refPending || (reqValid && !rowHit))) begin
      st.doPre = 1'b1;
    end else if (refPending) begin
      st.doRef = rpReady && rcReady;
    end else if (reqValid) begin
      if (rowHit) begin
        if (colOk) begin
          st.doRd = !reqWrite;
          st.doWr = reqWrite;
        end
      end else if (rpReady && rcReady) begin
        st.doAct = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  inProg <= 1'b0;
    else if (st.doAct)          inProg <= 1'b1;
    else if (st.doRd || st.doWr) inProg <= 1'b0;
  end

  assign reqDone = st.doRd || st.doWr;

  one_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.doAct, st.doPre, st.doRd, st.doWr, st.doRef}));

  // R4
  close_after_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    (closePolicy && (st.doRd || st.doWr)) |=> st.doPre);
endmodule

// File: rtl/bankSeqData.sv
module bankSeqData
  import bankSeqPkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 6,
  parameter int T_RC  = 10,
  parameter int T_WTR = 4,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      st,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic             refreshTick,
  output logic             rowOpen,
  output logic [ROW_W-1:0] openRow,
  output logic             refPending,
  output logic             rcReady,
  output logic             rcdReady,
  output logic             rpReady,
  output logic             wtrReady,
  output logic             cmdValid,
  output cmdKind_e         cmdKind,
  output logic [ROW_W-1:0] cmdRow,
  output logic [COL_W-1:0] cmdCol
);
  localparam int NT = 4;
  localparam int LIM [NT] = '{T_RC, T_RCD, T_RP, T_WTR};
  localparam int SW = $clog2(T_RC + T_RCD + T_RP + T_WTR + 2);

  logic [NT-1:0]    tLoad, tReady;
  logic             rowOpenQ, refPendQ;
  logic [ROW_W-1:0] openRowQ, refRowQ;

  // index 0 activate spacing, 1 activate-to-column, 2 precharge-to-activate, 3 write-to-read
  assign tLoad = {st.doWr, st.doPre, st.doAct, st.doAct | st.doRef};

  generate
    for (genvar i = 0; i < NT; i++) begin : gTimer
      seqDelayTimer #(.LIMIT(LIM[i])) uTimer (
        .clk   (clk),
        .rstN  (rstN),
        .load  (tLoad[i]),
        .ready (tReady[i])
      );
    end
  endgenerate

  assign rcReady  = tReady[0];
  assign rcdReady = tReady[1];
  assign rpReady  = tReady[2];
  assign wtrReady = tReady[3];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowOpenQ <= 1'b0;
      openRowQ <= '0;
      refRowQ  <= '0;
      refPendQ <= 1'b0;
    end else begin
      if (st.doAct) begin
        rowOpenQ <= 1'b1;
        openRowQ <= reqRow;
      end else if (st.doPre) begin
        rowOpenQ <= 1'b0;
      end
      if (st.doRef) refRowQ <= refRowQ + 1'b1;
      refPendQ <= (refPendQ && !st.doRef) || refreshTick;
    end
  end

  assign rowOpen    = rowOpenQ;
  assign openRow    = openRowQ;
  assign refPending = refPendQ;
  assign cmdValid   = |st;

  always_comb begin
    cmdKind = CMD_NOP;
    cmdRow  = '0;
    cmdCol  = '0;
    if (st.doAct) begin
      cmdKind = CMD_ACT;
      cmdRow  = reqRow;
    end else if (st.doPre) begin
      cmdKind = CMD_PRE;
      cmdRow  = openRowQ;
    end else if (st.doRd) begin
      cmdKind = CMD_RD;
      cmdRow  = openRowQ;
      cmdCol  = reqCol;
    end else if (st.doWr) begin
      cmdKind = CMD_WR;
      cmdRow  = openRowQ;
      cmdCol  = reqCol;
    end else if (st.doRef) begin
      cmdKind = CMD_REF;
      cmdRow  = refRowQ;
    end
  end

  // saturating cycle counts since the last command of each kind, for the checks below
  logic [SW-1:0] sinceAct, sinceWr, sincePre;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAct <= '1;
      sinceWr  <= '1;
      sincePre <= '1;
    end else begin
      sinceAct <= (st.doAct || st.doRef) ? SW'(1) : ((sinceAct == '1) ? sinceAct : sinceAct + 1'b1);
      sinceWr  <= st.doWr  ? SW'(1) : ((sinceWr  == '1) ? sinceWr  : sinceWr  + 1'b1);
      sincePre <= st.doPre ? SW'(1) : ((sincePre == '1) ? sincePre : sincePre + 1'b1);
    end
  end

  // R1
  col_needs_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.doRd || st.doWr) |-> (rowOpenQ && (sinceAct >= SW'(T_RCD))));

  // R3
  pre_before_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.doAct || st.doRef) |-> (!rowOpenQ && (sincePre >= SW'(T_RP))));

  // R5
  act_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.doAct || st.doRef) |-> (sinceAct >= SW'(T_RC)));

  // R6
  wtr_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.doRd |-> (sinceWr >= SW'(T_WTR)));

  // R8
  ref_when_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.doRef |-> refPendQ);
endmodule

// File: rtl/bankRowSequencer.sv
module bankRowSequencer
  import bankSeqPkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 6,
  parameter int T_RC  = 10,
  parameter int T_WTR = 4,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             closePolicy,
  input  logic             reqValid,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic             reqWrite,
  input  logic             refreshTick,
  output logic             reqDone,
  output logic             cmdValid,
  output logic [2:0]       cmdKind,
  output logic [ROW_W-1:0] cmdRow,
  output logic [COL_W-1:0] cmdCol,
  output logic             rowOpen,
  output logic [ROW_W-1:0] openRow
);
  seqStrobes_t      st;
  cmdKind_e         kindE;
  logic             refPending, rcReady, rcdReady, rpReady, wtrReady;

  bankSeqCtrl #(.ROW_W(ROW_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .closePolicy (closePolicy),
    .reqValid    (reqValid),
    .reqRow      (reqRow),
    .reqWrite    (reqWrite),
    .rowOpen     (rowOpen),
    .openRow     (openRow),
    .refPending  (refPending),
    .rcReady     (rcReady),
    .rcdReady    (rcdReady),
    .rpReady     (rpReady),
    .wtrReady    (wtrReady),
    .st          (st),
    .reqDone     (reqDone)
  );

  bankSeqData #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RC(T_RC),
    .T_WTR(T_WTR), .T_RCD(T_RCD), .T_RP(T_RP)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .reqRow      (reqRow),
    .reqCol      (reqCol),
    .refreshTick (refreshTick),
    .rowOpen     (rowOpen),
    .openRow     (openRow),
    .refPending  (refPending),
    .rcReady     (rcReady),
    .rcdReady    (rcdReady),
    .rpReady     (rpReady),
    .wtrReady    (wtrReady),
    .cmdValid    (cmdValid),
    .cmdKind     (kindE),
    .cmdRow      (cmdRow),
    .cmdCol      (cmdCol)
  );

  assign cmdKind = kindE;
endmodule

// File: tb/tb_bankRowSequencer.sv
module tb_bankRowSequencer;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 4;
  localparam int COL_W = 6;
  localparam int T_RC  = 10;
  localparam int T_WTR = 4;
  localparam int T_RCD = 3;
  localparam int T_RP  = 3;
  localparam int LOGSZ = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic closePolicy = 1'b0;
  logic reqValid = 1'b0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic reqWrite = 1'b0;
  logic refreshTick = 1'b0;
  logic reqDone, cmdValid, rowOpen;
  logic [2:0] cmdKind;
  logic [ROW_W-1:0] cmdRow, openRow;
  logic [COL_W-1:0] cmdCol;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int logN = 0;
  int logKind [LOGSZ];
  int logRow  [LOGSZ];
  int logCol  [LOGSZ];
  int logCyc  [LOGSZ];

  bankRowSequencer #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RC(T_RC),
    .T_WTR(T_WTR), .T_RCD(T_RCD), .T_RP(T_RP)
  ) dut (
    .clk(clk), .rstN(rstN), .closePolicy(closePolicy), .reqValid(reqValid),
    .reqRow(reqRow), .reqCol(reqCol), .reqWrite(reqWrite), .refreshTick(refreshTick),
    .reqDone(reqDone), .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdRow(cmdRow),
    .cmdCol(cmdCol), .rowOpen(rowOpen), .openRow(openRow)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // command log, sampled mid-cycle
  always @(negedge clk) begin
    #1;
    if (cmdValid && logN < LOGSZ) begin
      logKind[logN] = int'(cmdKind);
      logRow[logN]  = int'(cmdRow);
      logCol[logN]  = int'(cmdCol);
      logCyc[logN]  = cyc;
      logN = logN + 1;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string tag, input int actual, input int expected, input string what);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitDone(input string tag);
    int waitN = 0;
    bit got = 1'b0;
    while (!got && waitN < 100) begin
      #1;
      got = reqDone;
      if (!got) begin
        @(negedge clk);
        waitN++;
      end
    end
    chk(tag, int'(got), 1, "request completion");
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic access(input string tag, input int row, input int col, input bit wr);
    @(negedge clk);
    reqValid = 1'b1;
    reqRow   = ROW_W'(row);
    reqCol   = COL_W'(col);
    reqWrite = wr;
    waitDone(tag);
  endtask

  task automatic doReset(input bit policy, input bit check);
    @(negedge clk);
    rstN = 1'b0;
    closePolicy = policy;
    reqValid = 1'b0;
    refreshTick = 1'b0;
    idle(3);
    if (check) begin
      #1;
      chk("R9", int'(cmdValid), 0, "no command in reset");
      chk("R9", int'(rowOpen), 0, "buffer closed in reset");
      chk("R1", int'(reqDone), 0, "no done in reset");
    end
    rstN = 1'b1;
    idle(2);
  endtask

  task automatic testMissOpen();
    int b = logN;
    access("R1", 5, 3, 1'b0);
    chk("R1", logN - b, 2, "commands for miss on closed bank");
    chk("R1", logKind[b], 1, "first command activate");
    chk("R1", logRow[b], 5, "activate row");
    chk("R1", logKind[b+1], 2, "then read");
    chk("R1", logCol[b+1], 3, "read column");
    chk("R1", logCyc[b+1] - logCyc[b], T_RCD, "activate to read gap");
    #1;
    chk("R9", int'(rowOpen), 1, "row open after access");
    chk("R9", int'(openRow), 5, "open row index");
  endtask

  task automatic testHit();
    int b = logN;
    access("R2", 5, 7, 1'b0);
    chk("R2", logN - b, 1, "single command on row hit");
    chk("R2", logKind[b], 2, "hit served by read");
    chk("R2", logCol[b], 7, "hit column");
  endtask

  task automatic testWtr();
    int b = logN;
    access("R6", 5, 1, 1'b1);
    access("R6", 5, 2, 1'b0);
    chk("R6", logKind[b], 3, "write on hit");
    chk("R6", logKind[b+1], 2, "read after write");
    chk("R6", logCyc[b+1] - logCyc[b], T_WTR, "write to read gap");
  endtask

  task automatic testConflict();
    int b;
    idle(12);
    b = logN;
    access("R3", 9, 0, 1'b0);
    access("R5", 2, 1, 1'b0);
    chk("R3", logKind[b], 4, "precharge first on conflict");
    chk("R3", logRow[b], 5, "precharge of old row");
    chk("R3", logKind[b+1], 1, "then activate");
    chk("R3", logRow[b+1], 9, "activate new row");
    chk("R3", logCyc[b+1] - logCyc[b], T_RP, "precharge to activate gap");
    chk("R5", logKind[b+3], 4, "second conflict precharge");
    chk("R5", logKind[b+4], 1, "second activate");
    chk("R5", logCyc[b+4] - logCyc[b+1], T_RC, "activate to activate gap");
    #1;
    chk("R9", int'(openRow), 2, "open row after conflicts");
  endtask

  task automatic testRefreshOpen();
    int b;
    idle(12);
    b = logN;
    @(negedge clk);
    refreshTick = 1'b1;
    @(negedge clk);
    refreshTick = 1'b0;
    reqValid = 1'b1;
    reqRow = ROW_W'(2);
    reqCol = COL_W'(4);
    reqWrite = 1'b0;
    waitDone("R8");
    chk("R8", logKind[b], 4, "refresh precharges open row before hit");
    chk("R8", logKind[b+1], 5, "refresh before request");
    chk("R7", logRow[b+1], 0, "first refresh row after reset");
    chk("R8", logCyc[b+1] - logCyc[b], T_RP, "precharge to refresh gap");
    chk("R8", logKind[b+2], 1, "request reopens row");
    chk("R5", logCyc[b+2] - logCyc[b+1], T_RC, "refresh to activate gap");
    chk("R8", logKind[b+3], 2, "request read");
    chk("R8", logCol[b+3], 4, "request read column");
  endtask

  task automatic testClosePage();
    int b = logN;
    int b2;
    access("R4", 4, 3, 1'b1);
    idle(1);
    chk("R4", logKind[b], 1, "activate in close mode");
    chk("R4", logKind[b+1], 3, "write");
    chk("R4", logKind[b+2], 4, "precharge after write");
    chk("R4", logCyc[b+2] - logCyc[b+1], 1, "precharge one cycle after column");
    chk("R4", logRow[b+2], 4, "precharge row");
    #1;
    chk("R9", int'(rowOpen), 0, "closed after close-page access");
    idle(12);
    b2 = logN;
    access("R4", 4, 5, 1'b0);
    idle(1);
    chk("R4", logKind[b2], 1, "same row starts with activate");
    chk("R4", logKind[b2+1], 2, "then read");
    chk("R4", logKind[b2+2], 4, "then precharge");
  endtask

  task automatic testRefreshMidAccess();
    int b;
    idle(12);
    b = logN;
    @(negedge clk);
    reqValid = 1'b1;
    reqRow = ROW_W'(7);
    reqCol = COL_W'(1);
    reqWrite = 1'b0;
    @(negedge clk);
    refreshTick = 1'b1;
    @(negedge clk);
    refreshTick = 1'b0;
    waitDone("R8");
    idle(12);
    chk("R8", logKind[b], 1, "activate before tick");
    chk("R8", logKind[b+1], 2, "access finishes before refresh");
    chk("R8", logCyc[b+1] - logCyc[b], T_RCD, "column not delayed by refresh");
    chk("R8", logKind[b+2], 4, "precharge after access");
    chk("R8", logKind[b+3], 5, "refresh after access");
    chk("R7", logRow[b+3], 0, "refresh row after reset");
    chk("R5", logCyc[b+3] - logCyc[b], T_RC, "activate to refresh gap");
  endtask

  task automatic testRefreshWrap();
    int b = logN;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      refreshTick = 1'b1;
      @(negedge clk);
      refreshTick = 1'b0;
      idle(11);
    end
    chk("R7", logN - b, 16, "one refresh per tick");
    for (int i = 0; i < 16; i++) begin
      chk("R7", logKind[b+i], 5, "refresh kind");
      chk("R7", logRow[b+i], (i + 1) % 16, "refresh row sequence");
    end
  endtask

  initial begin
    doReset(1'b0, 1'b1);
    testMissOpen();
    testHit();
    testWtr();
    testConflict();
    testRefreshOpen();
    doReset(1'b1, 1'b0);
    testClosePage();
    testRefreshMidAccess();
    testRefreshWrap();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule